// File: doc/BRIEF.md
# Per-Line Interrupt Vector Arbiter

This block gathers interrupt requests for a serial interface with several lines and turns them into two master requests and a vector for each acknowledge. Each line has three pending bits. Two belong to the receive group: one for a received character and one for a change of dataset (modem) state. The third belongs to the transmit group and means the transmitter is ready. Event logic elsewhere raises and lowers these bits through a set strobe and a clear strobe. Each strobe carries a line index and a source code.

The block drives a receive master request and a transmit master request. Each group has an acknowledge pulse. On an acknowledge, the block picks the lowest-numbered active line that has a request pending in that group and clears that line's bits for the group. Both receive-side bits are cleared together, because the two receive causes share one vector. One cycle later the block presents the vector and a valid flag. Each line owns an 8-byte slot starting at the base vector, and the transmit vector sits 4 above the receive vector of the same line.

An input sets how many lines are active, from 1 up to a maximum that is a power of two. Lines at or above that count are masked out. The block also reports the size of the register window, which is 8 bytes per active line.

Top module: `ivec_arbiter`

## Requirements
- R1: While the synchronous reset `rst` is high, every pending bit is cleared. Through the first cycle after reset, `rx_irq`, `tx_irq`, `rx_vec_vld` and `tx_vec_vld` are low.
- R2: `rx_irq` is high in the cycle after any edge that leaves a received-character bit (source code 0) or a dataset bit (source code 1) pending on an active line, and low otherwise.
- R3: `tx_irq` is high in the cycle after any edge that leaves a transmit bit (source code 2) pending on an active line, and low otherwise.
- R4: On an acknowledge, the winning line is the lowest-numbered active line with a request pending in the acknowledged group.
- R5: A `rx_ack` clears both the received-character bit and the dataset bit of the winning line and nothing else. A `tx_ack` clears only the transmit bit of its winning line.
- R6: The receive vector is `base_vec + 8*line` and the transmit vector is `base_vec + 8*line + 4`, both taken modulo 2^VEC_W.
- R7: An acknowledge when the group has nothing pending still produces a valid vector, and that vector is 0.
- R8: `rx_vec_vld` and `tx_vec_vld` are high for exactly the one cycle after their acknowledge pulse. The vector is held in a register and is valid in that same cycle.
- R9: If a set strobe hits a bit in the same cycle as a clear of that bit, whether from an acknowledge or from the clear strobe, the bit ends up set.
- R10: A set strobe whose line index is at or above `active_lines` is ignored. Pending bits of lines at or above `active_lines` take no part in requests or arbitration.
- R11: A clear strobe clears exactly the one bit named by its source code (0, 1 or 2) and line index. Source code 3 has no effect on either strobe.
- R12: `win_bytes` equals 8 times `active_lines`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active_lines | input | LW+1 | Number of active lines, 1 to MAX_LINES |
| base_vec | input | VEC_W | Vector of line 0, receive group |
| set_valid | input | 1 | Set strobe |
| set_src | input | 2 | Source of the set: 0 receive, 1 dataset, 2 transmit |
| set_line | input | LW | Line index of the set |
| clr_valid | input | 1 | Clear strobe |
| clr_src | input | 2 | Source of the clear, same coding as set_src |
| clr_line | input | LW | Line index of the clear |
| rx_ack | input | 1 | Acknowledge pulse for the receive group |
| tx_ack | input | 1 | Acknowledge pulse for the transmit group |
| rx_irq | output | 1 | Receive master request |
| tx_irq | output | 1 | Transmit master request |
| rx_vec_vld | output | 1 | Receive vector valid |
| rx_vec | output | VEC_W | Receive vector |
| tx_vec_vld | output | 1 | Transmit vector valid |
| tx_vec | output | VEC_W | Transmit vector |
| win_bytes | output | LW+4 | Register window size in bytes |

## Verification
Random traffic mixes set strobes, clear strobes and acknowledges on all three sources, with a random base vector. This shows whether the priority pick and the vector arithmetic hold when many lines are pending at once. Directed patterns cover the cases random traffic seldom reaches:
- Only the dataset bit pending, which shows whether both receive causes share the receive request and are both cleared.
- Acknowledges with nothing pending, which should return vector 0.
- A set and a clear on the same bit in the same cycle, which shows that the set wins.
- Set strobes and pending bits on lines above a reduced active count, which should be masked.
- A reset in the middle of traffic.

// File: rtl/ivec_pkg.sv
package ivec_pkg;

    // Source codes carried by the set and clear strobes
    typedef enum logic [1:0] {
        SRC_RXCHR = 2'd0,
        SRC_DSCHG = 2'd1,
        SRC_TXRDY = 2'd2,
        SRC_NONE  = 2'd3
    } src_e;

    localparam int NUM_SRC   = 3;
    localparam int SLOT_SHFT = 3;   // 8 bytes per line slot
    localparam int TX_OFFSET = 4;   // transmit vector offset within a slot

    // Result of a priority pick
    typedef struct packed {
        logic        found;
        logic [15:0] idx;
    } pick_t;

endpackage

// File: rtl/ivec_req_bank.sv
module ivec_req_bank #(
    parameter int N  = 16,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  lane_mask,
    input  logic          set_en,
    input  logic [LW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [LW-1:0] clr_idx,
    input  logic [N-1:0]  ack_clr,
    output logic [N-1:0]  pend
);
    logic [N-1:0] set_hit;
    logic [N-1:0] clr_hit;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign set_hit[i] = set_en && (set_idx == LW'(i)) && lane_mask[i];
        assign clr_hit[i] = (clr_en && (clr_idx == LW'(i))) || ack_clr[i];

        always_ff @(posedge clk) begin
            if (rst)
                pend[i] <= 1'b0;
            else if (set_hit[i])
                pend[i] <= 1'b1;
            else if (clr_hit[i])
                pend[i] <= 1'b0;
        end
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_hit) |=> ((pend & $past(set_hit)) == $past(set_hit)));

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (|(ack_clr & ~set_hit)) |=> ((pend & $past(ack_clr & ~set_hit)) == '0));

endmodule

// File: rtl/ivec_prio_pick.sv
module ivec_prio_pick #(
    parameter int N  = 16,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [LW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = LW'(i);
            end
        end
    end

    // R4
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> (((N'(1) << idx) - N'(1)) & req) == '0);

endmodule

// File: rtl/ivec_vec_reg.sv
module ivec_vec_reg #(
    parameter int N      = 16,
    parameter int LW     = $clog2(N),
    parameter int VEC_W  = 9,
    parameter int OFFSET = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    input  logic             found,
    input  logic [LW-1:0]    idx,
    input  logic [VEC_W-1:0] base_vec,
    output logic             vld,
    output logic [VEC_W-1:0] vec
);
    logic [VEC_W-1:0] vec_next;

    always_comb begin
        if (found)
            vec_next = base_vec + VEC_W'({idx, 3'b000}) + VEC_W'(OFFSET);
        else
            vec_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
            vec <= '0;
        end else begin
            vld <= ack;
            if (ack)
                vec <= vec_next;
        end
    end

    // R8
    vld_follows_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> vld);

    // R8
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !ack |=> !vld);

    // R7
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !found) |=> (vec == '0));

endmodule

// File: rtl/ivec_arbiter.sv
module ivec_arbiter
    import ivec_pkg::*;
#(
    parameter int MAX_LINES = 16,
    parameter int VEC_W     = 9,
    parameter int LW        = $clog2(MAX_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LW:0]      active_lines,
    input  logic [VEC_W-1:0] base_vec,
    input  logic             set_valid,
    input  logic [1:0]       set_src,
    input  logic [LW-1:0]    set_line,
    input  logic             clr_valid,
    input  logic [1:0]       clr_src,
    input  logic [LW-1:0]    clr_line,
    input  logic             rx_ack,
    input  logic             tx_ack,
    output logic             rx_irq,
    output logic             tx_irq,
    output logic             rx_vec_vld,
    output logic [VEC_W-1:0] rx_vec,
    output logic             tx_vec_vld,
    output logic [VEC_W-1:0] tx_vec,
    output logic [LW+3:0]    win_bytes
);
    typedef logic [LW:0] cnt_t;

    logic [MAX_LINES-1:0]               lane_mask;
    logic [NUM_SRC-1:0][MAX_LINES-1:0]  pend;
    logic [NUM_SRC-1:0][MAX_LINES-1:0]  ack_clr;
    logic [MAX_LINES-1:0]               rx_req, tx_req;
    logic                               rx_found, tx_found;
    logic [LW-1:0]                      rx_idx, tx_idx;
    logic [MAX_LINES-1:0]               rx_win_oh, tx_win_oh;

    for (genvar i = 0; i < MAX_LINES; i++) begin : g_mask
        assign lane_mask[i] = active_lines > cnt_t'(i);
    end

    assign win_bytes = {active_lines, 3'b000};

    // Acknowledge clears, per source
    assign rx_win_oh = (rx_ack && rx_found) ? (MAX_LINES'(1) << rx_idx) : '0;
    assign tx_win_oh = (tx_ack && tx_found) ? (MAX_LINES'(1) << tx_idx) : '0;
    assign ack_clr[SRC_RXCHR] = rx_win_oh;
    assign ack_clr[SRC_DSCHG] = rx_win_oh;
    assign ack_clr[SRC_TXRDY] = tx_win_oh;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_bank
        ivec_req_bank #(.N(MAX_LINES), .LW(LW)) bank_i (
            .clk       (clk),
            .rst       (rst),
            .lane_mask (lane_mask),
            .set_en    (set_valid && (set_src == 2'(s))),
            .set_idx   (set_line),
            .clr_en    (clr_valid && (clr_src == 2'(s))),
            .clr_idx   (clr_line),
            .ack_clr   (ack_clr[s]),
            .pend      (pend[s])
        );
    end

    assign rx_req = (pend[SRC_RXCHR] | pend[SRC_DSCHG]) & lane_mask;
    assign tx_req = pend[SRC_TXRDY] & lane_mask;
    assign rx_irq = |rx_req;
    assign tx_irq = |tx_req;

    ivec_prio_pick #(.N(MAX_LINES), .LW(LW)) rx_pick_i (
        .clk (clk), .rst (rst), .req (rx_req), .found (rx_found), .idx (rx_idx)
    );

    ivec_prio_pick #(.N(MAX_LINES), .LW(LW)) tx_pick_i (
        .clk (clk), .rst (rst), .req (tx_req), .found (tx_found), .idx (tx_idx)
    );

    ivec_vec_reg #(.N(MAX_LINES), .LW(LW), .VEC_W(VEC_W), .OFFSET(0)) rx_vec_i (
        .clk (clk), .rst (rst), .ack (rx_ack), .found (rx_found), .idx (rx_idx),
        .base_vec (base_vec), .vld (rx_vec_vld), .vec (rx_vec)
    );

    ivec_vec_reg #(.N(MAX_LINES), .LW(LW), .VEC_W(VEC_W), .OFFSET(TX_OFFSET)) tx_vec_i (
        .clk (clk), .rst (rst), .ack (tx_ack), .found (tx_found), .idx (tx_idx),
        .base_vec (base_vec), .vld (tx_vec_vld), .vec (tx_vec)
    );

    // R2
    rx_irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_irq) && $stable(active_lines)) |-> $past(set_valid));

    // R3
    tx_irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_irq) && $stable(active_lines)) |-> $past(set_valid));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!rx_irq && !tx_irq && !rx_vec_vld && !tx_vec_vld));

endmodule

// File: tb/ivec_arbiter_tb_top.sv
module ivec_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int LW = 4;
    localparam int VW = 9;

    logic          clk = 1'b0;
    logic          rst;
    logic [LW:0]   active_lines;
    logic [VW-1:0] base_vec;
    logic          set_valid, clr_valid, rx_ack, tx_ack;
    logic [1:0]    set_src, clr_src;
    logic [LW-1:0] set_line, clr_line;
    logic          rx_irq, tx_irq, rx_vec_vld, tx_vec_vld;
    logic [VW-1:0] rx_vec, tx_vec;
    logic [LW+3:0] win_bytes;

    int checks = 0;
    int fails  = 0;

    // Reference state
    logic [N-1:0] m_rx, m_ds, m_tx;
    logic [VW-1:0] e_rvec, e_tvec;
    logic e_rvld, e_tvld;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivec_arbiter #(.MAX_LINES(N), .VEC_W(VW)) dut_i (
        .clk, .rst, .active_lines, .base_vec,
        .set_valid, .set_src, .set_line,
        .clr_valid, .clr_src, .clr_line,
        .rx_ack, .tx_ack,
        .rx_irq, .tx_irq, .rx_vec_vld, .rx_vec, .tx_vec_vld, .tx_vec, .win_bytes
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] act_mask();
        if (int'(active_lines) >= N) return '1;
        return (N'(1) << active_lines) - N'(1);
    endfunction

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [VW-1:0] vec_of(input int ln, input int ofs);
        return VW'(int'(base_vec) + 8 * ln + ofs);
    endfunction

    task automatic idle();
        set_valid = 0; clr_valid = 0; rx_ack = 0; tx_ack = 0;
        set_src = 0; clr_src = 0; set_line = 0; clr_line = 0;
    endtask

    // Called after a negedge with inputs driven; advances one edge and checks.
    task automatic step(input string tag);
        logic [N-1:0] mk;
        int rw, tw;
        mk = act_mask();
        rw = lowest((m_rx | m_ds) & mk);
        tw = lowest(m_tx & mk);
        e_rvld = rx_ack;
        e_tvld = tx_ack;
        e_rvec = (rw >= 0) ? vec_of(rw, 0) : '0;
        e_tvec = (tw >= 0) ? vec_of(tw, 4) : '0;
        if (rx_ack && rw >= 0) begin m_rx[rw] = 0; m_ds[rw] = 0; end
        if (tx_ack && tw >= 0) m_tx[tw] = 0;
        if (clr_valid) begin
            case (clr_src)
                2'd0: m_rx[clr_line] = 0;
                2'd1: m_ds[clr_line] = 0;
                2'd2: m_tx[clr_line] = 0;
                default: ;
            endcase
        end
        if (set_valid && int'(set_line) < int'(active_lines)) begin
            case (set_src)
                2'd0: m_rx[set_line] = 1;
                2'd1: m_ds[set_line] = 1;
                2'd2: m_tx[set_line] = 1;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        chk(rx_irq == |((m_rx | m_ds) & mk), {tag, " R2 rx_irq"}, rx_irq, |((m_rx | m_ds) & mk));
        chk(tx_irq == |(m_tx & mk), {tag, " R3 tx_irq"}, tx_irq, |(m_tx & mk));
        chk(rx_vec_vld == e_rvld, {tag, " R8 rx_vld"}, rx_vec_vld, e_rvld);
        chk(tx_vec_vld == e_tvld, {tag, " R8 tx_vld"}, tx_vec_vld, e_tvld);
        if (e_rvld) chk(rx_vec == e_rvec, {tag, " R4/R6 rx_vec"}, rx_vec, e_rvec);
        if (e_tvld) chk(tx_vec == e_tvec, {tag, " R4/R6 tx_vec"}, tx_vec, e_tvec);
        idle();
    endtask

    task automatic do_set(input int src, input int ln, input string tag);
        set_valid = 1; set_src = 2'(src); set_line = LW'(ln);
        step(tag);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd4242));
        idle();
        rst = 1; active_lines = 5'd16; base_vec = 9'h100;
        m_rx = '0; m_ds = '0; m_tx = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!rx_irq && !tx_irq, "R1 irqs after reset", {rx_irq, tx_irq}, 0);
        chk(!rx_vec_vld && !tx_vec_vld, "R1 vld after reset", {rx_vec_vld, tx_vec_vld}, 0);
        chk(win_bytes == 8'd128, "R12 window 16 lines", win_bytes, 128);

        // R7 ack with nothing pending
        rx_ack = 1; tx_ack = 1; step("R7 empty ack");
        chk(rx_vec == 0 && tx_vec == 0, "R7 empty vectors", rx_vec, 0);

        // R5 dataset-only request shares receive vector, both bits cleared
        do_set(1, 6, "R5 ds set");
        do_set(0, 6, "R5 rx set");
        do_set(0, 9, "R5 rx set other");
        rx_ack = 1; step("R5 ack ln6");
        chk(rx_vec == 9'h130, "R6 rx vec ln6", rx_vec, 9'h130);
        chk(rx_irq == 1, "R5 other line kept", rx_irq, 1);
        rx_ack = 1; step("R5 ack ln9");
        chk(rx_irq == 0, "R5 all cleared", rx_irq, 0);

        // R4/R6 transmit ordering
        do_set(2, 12, "R4 tx12");
        do_set(2, 3, "R4 tx3");
        tx_ack = 1; step("R4 tx ack");
        chk(tx_vec == 9'h11C, "R6 tx vec ln3", tx_vec, 9'h11C);
        tx_ack = 1; step("R4 tx ack2");
        chk(tx_vec == 9'h164, "R6 tx vec ln12", tx_vec, 9'h164);

        // R9 set beats acknowledge clear and explicit clear
        do_set(0, 2, "R9 prep");
        rx_ack = 1; set_valid = 1; set_src = 2'd0; set_line = 4'd2; step("R9 set+ack");
        chk(rx_irq == 1, "R9 bit survives ack", rx_irq, 1);
        clr_valid = 1; clr_src = 2'd0; clr_line = 4'd2;
        set_valid = 1; set_src = 2'd0; set_line = 4'd2; step("R9 set+clr");
        chk(rx_irq == 1, "R9 bit survives clr", rx_irq, 1);

        // R11 clear strobe hits only the named bit; code 3 inert
        do_set(2, 2, "R11 tx2");
        clr_valid = 1; clr_src = 2'd3; clr_line = 4'd2; step("R11 code3 clr");
        chk(rx_irq && tx_irq, "R11 code3 no effect", {rx_irq, tx_irq}, 3);
        clr_valid = 1; clr_src = 2'd2; clr_line = 4'd2; step("R11 tx clr");
        chk(rx_irq == 1 && tx_irq == 0, "R11 only tx cleared", {rx_irq, tx_irq}, 2);
        clr_valid = 1; clr_src = 2'd0; clr_line = 4'd2; step("R11 rx clr");

        // R10 inactive lines
        active_lines = 5'd4;
        step("R10 shrink");
        chk(win_bytes == 8'd32, "R12 window 4 lines", win_bytes, 32);
        do_set(0, 7, "R10 set above");
        chk(rx_irq == 0, "R10 set above ignored", rx_irq, 0);
        active_lines = 5'd16;
        step("R10 grow");
        chk(rx_irq == 0, "R10 bit never stored", rx_irq, 0);
        do_set(2, 10, "R10 tx10");
        active_lines = 5'd8;
        step("R10 mask");
        chk(tx_irq == 0, "R10 pending masked", tx_irq, 0);
        tx_ack = 1; step("R10 masked ack");
        chk(tx_vec == 0, "R10 masked ack vec 0", tx_vec, 0);
        active_lines = 5'd16;
        tx_ack = 1; step("R10 unmasked ack");

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 99) == 0) base_vec = VW'($urandom);
            if ($urandom_range(0, 199) == 0) active_lines = 5'($urandom_range(1, 16));
            set_valid = ($urandom_range(0, 2) != 0);
            set_src   = 2'($urandom);
            set_line  = LW'($urandom);
            clr_valid = ($urandom_range(0, 3) == 0);
            clr_src   = 2'($urandom);
            clr_line  = LW'($urandom);
            rx_ack    = ($urandom_range(0, 3) == 0);
            tx_ack    = ($urandom_range(0, 3) == 0);
            step("rand");
            chk(win_bytes == {active_lines, 3'b000}, "R12 rand window", win_bytes, {active_lines, 3'b000});
        end

        // R1 reset mid-traffic
        active_lines = 5'd16;
        do_set(0, 1, "R1 prep");
        do_set(2, 1, "R1 prep tx");
        rst = 1;
        @(negedge clk);
        rst = 0;
        m_rx = '0; m_ds = '0; m_tx = '0;
        @(negedge clk);
        chk(!rx_irq && !tx_irq, "R1 reset clears pend", {rx_irq, tx_irq}, 0);
        rx_ack = 1; step("R1 post-reset ack");
        chk(rx_vec == 0, "R1 empty after reset", rx_vec, 0);

        report();
    end
endmodule